// File: doc/BRIEF.md
# Peer Address Discovery Sequencer

This block runs the start-up handshake that finds the Ethernet hardware address of the single peer a point-to-point UDP link talks to. While the software-controlled hold input is high, the block stays parked. When hold falls, it starts one of two exchanges. In client mode it asks for the peer's address with an ARP request and keeps repeating that request each time a programmable cycle count runs out. In server mode it waits for the peer to ask first, and then answers.

The block does not build or parse frames. A neighbouring receive parser gives it one-cycle events that carry the decoded ARP fields. A neighbouring transmit builder acts on its one-cycle send commands. Busy stays high from reset until the peer address has been learned. The learned address is then held steady for the data path until hold is raised again.

Top module: `arp_init_ctrl`

## Requirements
- R1: During and straight after the synchronous active-low reset, busy is 1, peer_mac_valid is 0, peer_mac is 0, tmo_status is 0, and send_req, send_rep and tmo_irq are 0.
- R2: While hold_rst is 1, no send command is issued and busy stays 1. The first clock edge that samples hold_rst at 0 starts the sequence.
- R3: In client mode (server_mode = 0 at the start edge), send_req is a one-cycle pulse in the cycle right after the start edge.
- R4: In client mode, after tmo_cycles clock cycles pass with no accepted reply since the last send_req pulse, tmo_irq and send_req pulse together for one cycle. This repeats without limit. A tmo_cycles value of 0 behaves as 1.
- R5: tmo_status is set by the first timeout and stays at 1 until hold_rst is raised.
- R6: An ARP event is accepted only when rx_spa equals peer_ip and rx_tpa equals local_ip, and the opcode matches the mode. rx_is_reply = 1 (reply) is accepted in client mode, and only when rx_tha equals local_mac. rx_is_reply = 0 (request) is accepted in server mode. Every other event is ignored.
- R7: In client mode, an accepted reply loads rx_sha into peer_mac. In the next cycle busy is 0 and peer_mac_valid is 1. If a reply is accepted on the same edge as a timeout, the reply wins and no tmo_irq is raised.
- R8: In server mode, an accepted request loads rx_sha into peer_mac. In the next cycle send_rep pulses for one cycle while busy is already 0.
- R9: Once the address is learned, further ARP events are ignored and peer_mac stays unchanged until hold_rst is raised.
- R10: Raising hold_rst in any state aborts the sequence. From the next cycle, busy is 1, peer_mac_valid is 0, peer_mac is 0 and tmo_status is 0.
- R11: The mode is taken at the start edge only. A change of server_mode during the exchange has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_rst | input | 1 | Software hold; 1 parks the block, falling to 0 starts discovery |
| server_mode | input | 1 | 0 = client (ask first), 1 = server (answer) |
| local_ip | input | 32 | Own IPv4 address |
| peer_ip | input | 32 | Peer IPv4 address |
| local_mac | input | 48 | Own hardware address |
| tmo_cycles | input | 32 | Request retry period in clock cycles |
| rx_valid | input | 1 | One-cycle strobe for a decoded ARP event |
| rx_is_reply | input | 1 | 1 = ARP reply, 0 = ARP request |
| rx_sha | input | 48 | Sender hardware address of the event |
| rx_spa | input | 32 | Sender protocol address of the event |
| rx_tha | input | 48 | Target hardware address of the event |
| rx_tpa | input | 32 | Target protocol address of the event |
| send_req | output | 1 | One-cycle command to transmit an ARP request |
| send_rep | output | 1 | One-cycle command to transmit an ARP reply |
| peer_mac | output | 48 | Learned peer hardware address |
| peer_mac_valid | output | 1 | peer_mac holds a learned address |
| busy | output | 1 | Discovery not finished |
| tmo_irq | output | 1 | One-cycle pulse on each request timeout |
| tmo_status | output | 1 | Sticky flag: at least one timeout occurred |

## Verification
A wrong sequencer state shows at the ports within one cycle. A missed or extra start produces a send_req in the wrong cycle. A lost mode shows as a request in server mode. A stuck learned state shows as busy low while hold is high. A miscounting retry timer shifts every tmo_irq and resend pulse, so the first error appears at the first timeout, tmo_cycles cycles after the request. A filter error appears on the edge after the offending event, as an early busy fall or a changed peer_mac. For these reasons a behavioural model is compared against every output on every cycle.

// File: rtl/arp_init_pkg.sv
// Shared types for the peer address discovery sequencer.
// Assumes: four sequencing phases; the mode is encoded in the waiting phase.
package arp_init_pkg;

    typedef enum logic [1:0] {
        PH_PARKED      = 2'd0,
        PH_ASK_WAIT    = 2'd1,
        PH_LISTEN_WAIT = 2'd2,
        PH_LEARNED     = 2'd3
    } init_phase_t;

endpackage

// File: rtl/arp_rx_filter.sv
// Qualifies decoded ARP events against the configured addresses.
// Assumes: rx fields are valid only while rx_valid is high; purely combinational.
module arp_rx_filter #(
    parameter int IP_W  = 32,
    parameter int MAC_W = 48
) (
    input  logic             rx_valid,
    input  logic             rx_is_reply,
    input  logic [IP_W-1:0]  rx_spa,
    input  logic [IP_W-1:0]  rx_tpa,
    input  logic [MAC_W-1:0] rx_tha,
    input  logic [IP_W-1:0]  local_ip,
    input  logic [IP_W-1:0]  peer_ip,
    input  logic [MAC_W-1:0] local_mac,
    output logic             hit_reply,
    output logic             hit_request
);

    logic addr_pair_ok;

    // Protocol addresses must name the peer as sender and this node as target.
    always_comb begin
        addr_pair_ok = (rx_spa == peer_ip) && (rx_tpa == local_ip);
    end

    // Split by opcode; a reply must also be addressed to this node's hardware address.
    always_comb begin
        hit_reply   = rx_valid && addr_pair_ok && rx_is_reply && (rx_tha == local_mac);
        hit_request = rx_valid && addr_pair_ok && !rx_is_reply;
    end

endmodule

// File: rtl/arp_retry_timer.sv
// Counts cycles since the last request and flags when the retry period is used up.
// Assumes: restart has priority; a limit of zero expires every cycle like a limit of one.
module arp_retry_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);

    localparam int SUM_W = TMR_W + 1;

    logic [TMR_W-1:0] elapsed;
    logic [SUM_W-1:0] elapsed_next;

    // Widened increment so the compare never wraps.
    always_comb begin
        elapsed_next = {1'b0, elapsed} + SUM_W'(1);
        expire       = run && (elapsed_next >= {1'b0, limit});
    end

    // Elapsed-cycle register: cleared on restart, advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (restart) begin
            elapsed <= '0;
        end else if (run) begin
            elapsed <= elapsed_next[TMR_W-1:0];
        end
    end

endmodule

// File: rtl/arp_init_fsm.sv
// Sequencer for the discovery exchange: parks under hold, asks or listens, then latches the peer.
// Assumes: qualified hits from the filter and expiry from the retry timer; all outputs registered
// except busy/valid, which decode the phase register directly.
module arp_init_fsm
    import arp_init_pkg::*;
#(
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_rst,
    input  logic             server_mode,
    input  logic             hit_reply,
    input  logic             hit_request,
    input  logic [MAC_W-1:0] rx_sha,
    input  logic             expire,
    output logic             tmr_restart,
    output logic             tmr_run,
    output logic             send_req,
    output logic             send_rep,
    output logic             tmo_irq,
    output logic             tmo_status,
    output logic [MAC_W-1:0] peer_mac,
    output logic             learned
);

    init_phase_t phase;

    // Timer control: restart on each request issue, count only while waiting for a reply.
    always_comb begin
        tmr_run     = (phase == PH_ASK_WAIT) && !hold_rst;
        tmr_restart = ((phase == PH_PARKED) && !hold_rst && !server_mode)
                    || ((phase == PH_ASK_WAIT) && expire);
        learned     = (phase == PH_LEARNED);
    end

    // Phase, captured address, command pulses and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_PARKED;
            peer_mac   <= '0;
            send_req   <= 1'b0;
            send_rep   <= 1'b0;
            tmo_irq    <= 1'b0;
            tmo_status <= 1'b0;
        end else begin
            send_req <= 1'b0;
            send_rep <= 1'b0;
            tmo_irq  <= 1'b0;
            if (hold_rst) begin
                phase      <= PH_PARKED;
                peer_mac   <= '0;
                tmo_status <= 1'b0;
            end else begin
                unique case (phase)
                    PH_PARKED: begin
                        if (server_mode) begin
                            phase <= PH_LISTEN_WAIT;
                        end else begin
                            phase    <= PH_ASK_WAIT;
                            send_req <= 1'b1;
                        end
                    end
                    PH_ASK_WAIT: begin
                        if (hit_reply) begin
                            peer_mac <= rx_sha;
                            phase    <= PH_LEARNED;
                        end else if (expire) begin
                            send_req   <= 1'b1;
                            tmo_irq    <= 1'b1;
                            tmo_status <= 1'b1;
                        end
                    end
                    PH_LISTEN_WAIT: begin
                        if (hit_request) begin
                            peer_mac <= rx_sha;
                            send_rep <= 1'b1;
                            phase    <= PH_LEARNED;
                        end
                    end
                    PH_LEARNED: begin
                        phase <= PH_LEARNED;
                    end
                    default: begin
                        phase <= PH_PARKED;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/arp_init_ctrl.sv
// Top of the peer address discovery sequencer: filter, retry timer and sequencer.
// Assumes: one decoded ARP event per rx_valid cycle; frame building is done downstream.
module arp_init_ctrl #(
    parameter int IP_W  = 32,
    parameter int MAC_W = 48,
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_rst,
    input  logic             server_mode,
    input  logic [IP_W-1:0]  local_ip,
    input  logic [IP_W-1:0]  peer_ip,
    input  logic [MAC_W-1:0] local_mac,
    input  logic [TMR_W-1:0] tmo_cycles,
    input  logic             rx_valid,
    input  logic             rx_is_reply,
    input  logic [MAC_W-1:0] rx_sha,
    input  logic [IP_W-1:0]  rx_spa,
    input  logic [MAC_W-1:0] rx_tha,
    input  logic [IP_W-1:0]  rx_tpa,
    output logic             send_req,
    output logic             send_rep,
    output logic [MAC_W-1:0] peer_mac,
    output logic             peer_mac_valid,
    output logic             busy,
    output logic             tmo_irq,
    output logic             tmo_status
);

    logic hit_reply;
    logic hit_request;
    logic expire;
    logic tmr_restart;
    logic tmr_run;
    logic learned;

    arp_rx_filter #(.IP_W(IP_W), .MAC_W(MAC_W)) u_filter (
        .rx_valid    (rx_valid),
        .rx_is_reply (rx_is_reply),
        .rx_spa      (rx_spa),
        .rx_tpa      (rx_tpa),
        .rx_tha      (rx_tha),
        .local_ip    (local_ip),
        .peer_ip     (peer_ip),
        .local_mac   (local_mac),
        .hit_reply   (hit_reply),
        .hit_request (hit_request)
    );

    arp_retry_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (tmr_run),
        .limit   (tmo_cycles),
        .expire  (expire)
    );

    arp_init_fsm #(.MAC_W(MAC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_rst    (hold_rst),
        .server_mode (server_mode),
        .hit_reply   (hit_reply),
        .hit_request (hit_request),
        .rx_sha      (rx_sha),
        .expire      (expire),
        .tmr_restart (tmr_restart),
        .tmr_run     (tmr_run),
        .send_req    (send_req),
        .send_rep    (send_rep),
        .tmo_irq     (tmo_irq),
        .tmo_status  (tmo_status),
        .peer_mac    (peer_mac),
        .learned     (learned)
    );

    // Status decode: busy until the peer address is learned.
    always_comb begin
        peer_mac_valid = learned;
        busy           = !learned;
    end

endmodule

// File: rtl/arp_init_checker.sv
// Port-level temporal checks for the discovery sequencer, bound to every instance of the top.
// Assumes: synchronous active-low reset; all properties are disabled while reset is low.
module arp_init_checker #(
    parameter int MAC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hold_rst,
    input logic             send_req,
    input logic             send_rep,
    input logic [MAC_W-1:0] peer_mac,
    input logic             peer_mac_valid,
    input logic             busy,
    input logic             tmo_irq,
    input logic             tmo_status
);

    assert_req_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        send_req |-> busy);

    assert_reply_after_learn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        send_rep |-> (!busy && peer_mac_valid));

    assert_irq_with_resend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> send_req);

    assert_status_follows_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> tmo_status);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_status && !hold_rst) |=> tmo_status);

    assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rst |=> (busy && !peer_mac_valid && (peer_mac == '0) && !tmo_status));

    assert_learned_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_mac_valid && !hold_rst) |=> (peer_mac_valid && $stable(peer_mac)));

    assert_single_command_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({send_req, send_rep}));

endmodule

bind arp_init_ctrl arp_init_checker #(.MAC_W(MAC_W)) u_arp_init_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .hold_rst       (hold_rst),
    .send_req       (send_req),
    .send_rep       (send_rep),
    .peer_mac       (peer_mac),
    .peer_mac_valid (peer_mac_valid),
    .busy           (busy),
    .tmo_irq        (tmo_irq),
    .tmo_status     (tmo_status)
);

// File: tb/test_arp_init_ctrl.sv
// Bench: behavioural reference model compared against every output on every cycle,
// plus directed checks at scenario points. Inputs change on falling edges.
module test_arp_init_ctrl;

    localparam logic [31:0] LOC_IP  = 32'hC0A8_0A01;
    localparam logic [31:0] PEER_IP = 32'hC0A8_0A02;
    localparam logic [47:0] LOC_MAC = 48'h0211_2233_4455;
    localparam logic [47:0] PEER_A  = 48'h02AA_BBCC_DDEE;
    localparam logic [47:0] PEER_B  = 48'h0266_7788_99AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold_rst = 1'b1;
    logic        server_mode = 1'b0;
    logic [31:0] tmo_cycles = 32'd5;
    logic        rx_valid = 1'b0;
    logic        rx_is_reply = 1'b0;
    logic [47:0] rx_sha = '0;
    logic [31:0] rx_spa = '0;
    logic [47:0] rx_tha = '0;
    logic [31:0] rx_tpa = '0;
    logic        send_req, send_rep, peer_mac_valid, busy, tmo_irq, tmo_status;
    logic [47:0] peer_mac;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    arp_init_ctrl i_arp_init_ctrl (
        .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .server_mode(server_mode),
        .local_ip(LOC_IP), .peer_ip(PEER_IP), .local_mac(LOC_MAC), .tmo_cycles(tmo_cycles),
        .rx_valid(rx_valid), .rx_is_reply(rx_is_reply), .rx_sha(rx_sha), .rx_spa(rx_spa),
        .rx_tha(rx_tha), .rx_tpa(rx_tpa), .send_req(send_req), .send_rep(send_rep),
        .peer_mac(peer_mac), .peer_mac_valid(peer_mac_valid), .busy(busy),
        .tmo_irq(tmo_irq), .tmo_status(tmo_status)
    );

    // ---------------- reference model ----------------
    int          m_ph = 0;   // 0 parked, 1 asking, 2 listening, 3 learned
    longint      m_cnt = 0;
    logic [47:0] m_mac = '0;
    bit          m_req = 0, m_rep = 0, m_irq = 0, m_stat = 0;

    always @(posedge clk) begin
        bit ok_rep, ok_req, addr_ok;
        longint lim;
        addr_ok = rx_valid && (rx_spa == PEER_IP) && (rx_tpa == LOC_IP);
        ok_rep  = addr_ok && rx_is_reply && (rx_tha == LOC_MAC);
        ok_req  = addr_ok && !rx_is_reply;
        lim     = (tmo_cycles == 0) ? 1 : longint'(tmo_cycles);
        m_req = 0; m_rep = 0; m_irq = 0;
        if (!rst_n) begin
            m_ph = 0; m_mac = '0; m_stat = 0; m_cnt = 0;
        end else if (hold_rst) begin
            m_ph = 0; m_mac = '0; m_stat = 0;
        end else if (m_ph == 0) begin
            if (server_mode) m_ph = 2;
            else begin m_ph = 1; m_req = 1; m_cnt = 0; end
        end else if (m_ph == 1) begin
            if (ok_rep) begin m_mac = rx_sha; m_ph = 3; end
            else if (m_cnt + 1 >= lim) begin m_req = 1; m_irq = 1; m_stat = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end else if (m_ph == 2) begin
            if (ok_req) begin m_mac = rx_sha; m_rep = 1; m_ph = 3; end
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R3", "send_req",       64'(send_req),       64'(m_req));
            chk("R8", "send_rep",       64'(send_rep),       64'(m_rep));
            chk("R4", "tmo_irq",        64'(tmo_irq),        64'(m_irq));
            chk("R5", "tmo_status",     64'(tmo_status),     64'(m_stat));
            chk("R7", "busy",           64'(busy),           64'(m_ph != 3));
            chk("R7", "peer_mac_valid", 64'(peer_mac_valid), 64'(m_ph == 3));
            chk("R9", "peer_mac",       64'(peer_mac),       64'(m_mac));
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL R2 watchdog actual=%0d cycles expected=end of stimulus", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Present one ARP event for one cycle; returns at the falling edge after it was sampled.
    task automatic arp_ev(input bit is_rep, input logic [47:0] sha, input logic [31:0] spa,
                          input logic [47:0] tha, input logic [31:0] tpa);
        rx_valid = 1'b1; rx_is_reply = is_rep; rx_sha = sha; rx_spa = spa;
        rx_tha = tha; rx_tpa = tpa;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "busy", 64'(busy), 64'd1);
        chk("R1", "peer_mac_valid", 64'(peer_mac_valid), 64'd0);
        chk("R1", "peer_mac", 64'(peer_mac), 64'd0);
        chk("R1", "pulses", 64'({send_req, send_rep, tmo_irq, tmo_status}), 64'd0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (4) @(negedge clk);
        // R2: held, nothing issued
        chk("R2", "send_req held", 64'(send_req), 64'd0);
        chk("R2", "busy held", 64'(busy), 64'd1);

        // Client mode with period 5
        hold_rst = 1'b0;
        @(negedge clk);
        chk("R3", "first request", 64'(send_req), 64'd1);
        repeat (5) @(negedge clk);
        chk("R4", "first timeout irq", 64'(tmo_irq), 64'd1);
        chk("R5", "status set", 64'(tmo_status), 64'd1);
        repeat (7) @(negedge clk);
        // R6: mismatching events ignored
        arp_ev(1'b1, PEER_A, 32'hC0A8_0A09, LOC_MAC, LOC_IP);
        arp_ev(1'b1, PEER_A, PEER_IP, LOC_MAC, 32'hC0A8_0A07);
        arp_ev(1'b1, PEER_A, PEER_IP, 48'h0211_2233_4456, LOC_IP);
        arp_ev(1'b0, PEER_A, PEER_IP, 48'h0, LOC_IP);
        chk("R6", "still busy", 64'(busy), 64'd1);
        arp_ev(1'b1, PEER_A, PEER_IP, LOC_MAC, LOC_IP);
        chk("R7", "learned mac", 64'(peer_mac), 64'(PEER_A));
        chk("R7", "busy low", 64'(busy), 64'd0);
        arp_ev(1'b1, PEER_B, PEER_IP, LOC_MAC, LOC_IP);
        repeat (2) @(negedge clk);
        chk("R9", "mac unchanged", 64'(peer_mac), 64'(PEER_A));

        // R10: abort
        hold_rst = 1'b1;
        @(negedge clk);
        chk("R10", "busy", 64'(busy), 64'd1);
        chk("R10", "mac cleared", 64'(peer_mac), 64'd0);
        chk("R10", "status cleared", 64'(tmo_status), 64'd0);
        @(negedge clk);

        // Server mode; mode flip mid-sequence must not matter
        server_mode = 1'b1;
        hold_rst = 1'b0;
        @(negedge clk);
        server_mode = 1'b0;
        arp_ev(1'b1, PEER_B, PEER_IP, LOC_MAC, LOC_IP);
        repeat (8) @(negedge clk);
        chk("R11", "no request after flip", 64'(send_req), 64'd0);
        chk("R11", "still waiting", 64'(busy), 64'd1);
        arp_ev(1'b0, PEER_B, PEER_IP, 48'h0, LOC_IP);
        chk("R8", "reply pulse", 64'(send_rep), 64'd1);
        chk("R8", "busy low", 64'(busy), 64'd0);
        chk("R8", "learned mac", 64'(peer_mac), 64'(PEER_B));

        // Period 0 behaves as 1: timeout every cycle, reply beats timeout
        hold_rst = 1'b1;
        repeat (2) @(negedge clk);
        tmo_cycles = 32'd0;
        hold_rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4", "irq every cycle", 64'(tmo_irq), 64'd1);
        arp_ev(1'b1, PEER_A, PEER_IP, LOC_MAC, LOC_IP);
        chk("R7", "reply wins irq", 64'(tmo_irq), 64'd0);
        chk("R7", "reply wins busy", 64'(busy), 64'd0);

        // Reply on exactly the expiry edge with period 3
        hold_rst = 1'b1;
        repeat (2) @(negedge clk);
        tmo_cycles = 32'd3;
        hold_rst = 1'b0;
        repeat (3) @(negedge clk);
        arp_ev(1'b1, PEER_B, PEER_IP, LOC_MAC, LOC_IP);
        chk("R7", "edge reply no irq", 64'(tmo_irq), 64'd0);
        chk("R7", "edge reply mac", 64'(peer_mac), 64'(PEER_B));
        repeat (3) @(negedge clk);

        done = 1'b1;
        mon_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule